// File: doc/BRIEF.md
# Asynchronous Serial Port with Nine-Bit Characters

This block is a full-duplex asynchronous serial transceiver that a processor drives through four byte-wide registers. A write to the data address loads a one-character transmit holding buffer; a read of the same address returns the most recently received character. Characters have one start bit (low), eight or nine data bits sent least significant bit first, and one stop bit (high). A programmable divider makes a tick at sixteen times the bit rate. The receiver finds the leading edge of a start bit, confirms it half a bit later, and then samples each following bit at its centre.

Status is kept in flags that software polls. Three interrupt request outputs combine those flags with enable bits. The overrun flag is held back until the older, valid character has been read out. Turning the transmitter off does not cut a frame short: whatever is already in the shift register, and whatever is waiting in the holding buffer, goes out first.

Top module: `uart9_port`

## Requirements
- R1: Register addresses are 0 data, 1 status, 2 control, 3 baud divisor. Read data appears on `bus_rdata` the cycle after `bus_rd`. After reset, control reads 0x02, status reads 0x04, `txd` is high and all interrupt outputs are low.
- R2: A transmitted 8-bit frame is a low start bit, the data bits LSB first, and a high stop bit. Each bit lasts 16*(divisor+1) clocks.
- R3: Control bit 2 selects nine data bits. The ninth transmitted bit is taken from control bit 0, which is write-only and reads as zero. The ninth received bit appears at control bit 1, which is read-only.
- R4: A received character is read from address 0. Status bit 0 (receive complete) sets when the character lands in the buffer and clears when address 0 is read.
- R5: If a character completes while the buffer still holds an unread one, the new character is discarded. Status bit 4 (overrun) reads 0 until the old character is read, and reads 1 after that.
- R6: The overrun flag clears when a later character is placed into the receive buffer.
- R7: Status bit 3 (framing error) is the inverse of the stop bit that was sampled for the buffered character.
- R8: Control bit 4 enables the receiver. While it is 0, none of status bits 0, 3 or 4 can set. Clearing it leaves flags that are already set unchanged.
- R9: Control bit 3 enables the transmitter. While it is 0, no new frame starts. If it is cleared during a frame, the frame in progress and any character waiting in the holding buffer are both still sent.
- R10: Status bit 2 (buffer empty) clears on a write to address 0 and sets when the buffer contents move into the shift register.
- R11: Status bit 1 (transmit complete) sets at the end of a stop bit if no character is waiting. Writing 1 to status bit 1 clears it.
- R12: `irq_rx`, `irq_tx` and `irq_empty` go high on the clock edge after their flag (status bit 0, 1 or 2) and their enable (control bit 7, 6 or 5) are both 1. They go low on the edge after either one clears.
- R13: A low pulse on `rxd` that is high again at the start-bit midpoint is rejected. No character is received, and the receiver then accepts the next genuine frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_rx | output | 1 | Receive-complete request |
| irq_tx | output | 1 | Transmit-complete request |
| irq_empty | output | 1 | Buffer-empty request |

## Verification
The hardest state to reach is the overrun case. A second complete frame has to arrive while the first is still unread, and the bench must show that the flag stays hidden until the read and only then appears. The stimulus sends two frames back to back without reading, checks status, reads the old character, and checks status again.

The deferred shutdown of the transmitter is a similar case. The bench fills the holding buffer while a frame is on the line and clears the enable at once. The scoreboard then expects both characters to appear on `txd`.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_DATA, PH_STOP} phase_t;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;
  localparam int OVS = 16;
  localparam logic [3:0] LAST_SUB = 4'(OVS - 1);
  localparam logic [3:0] MID_SUB  = 4'(OVS / 2 - 1);
endpackage

// File: rtl/uart9_baud.sv
module uart9_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
  import uart9_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       en,
  input  logic       chr9,
  input  logic       wr,
  input  logic [8:0] wdata,
  output logic       txd,
  output logic       buf_full,
  output logic       done_pulse
);
  logic [8:0] buf_q, shift_q;
  phase_t     ph;
  logic [3:0] sub, bit_i, nbits;
  logic       stop_end, load;

  assign stop_end = (ph == PH_STOP) && tick && (sub == LAST_SUB);
  assign load     = buf_full && (((ph == PH_IDLE) && en) || stop_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q      <= '0;
      shift_q    <= '0;
      buf_full   <= 1'b0;
      ph         <= PH_IDLE;
      sub        <= '0;
      bit_i      <= '0;
      nbits      <= 4'd8;
      txd        <= 1'b1;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (wr) begin
        buf_q    <= wdata;
        buf_full <= 1'b1;
      end else if (load) begin
        buf_full <= 1'b0;
      end
      if (load) begin
        shift_q <= buf_q;
        nbits   <= chr9 ? 4'd9 : 4'd8;
        ph      <= PH_START;
        sub     <= '0;
        txd     <= 1'b0;
      end else if (tick) begin
        case (ph)
          PH_START: begin
            if (sub == LAST_SUB) begin
              sub   <= '0;
              bit_i <= '0;
              ph    <= PH_DATA;
              txd   <= shift_q[0];
            end else sub <= sub + 1'b1;
          end
          PH_DATA: begin
            if (sub == LAST_SUB) begin
              sub     <= '0;
              shift_q <= shift_q >> 1;
              if (bit_i == nbits - 4'd1) begin
                ph  <= PH_STOP;
                txd <= 1'b1;
              end else begin
                bit_i <= bit_i + 1'b1;
                txd   <= shift_q[1];
              end
            end else sub <= sub + 1'b1;
          end
          PH_STOP: begin
            if (sub == LAST_SUB) begin
              ph         <= PH_IDLE;
              done_pulse <= 1'b1;
            end else sub <= sub + 1'b1;
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  // Disabled and idle: the line stays idle, no frame is started.
  assert_no_start_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IDLE && !en) |=> (ph == PH_IDLE));

  // The stop bit is always driven high.
  assert_stop_high_R2: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_STOP) |-> txd);
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       en,
  input  logic       chr9,
  input  logic       rxd,
  output logic       done,
  output logic [8:0] data,
  output logic       stop_bit
);
  logic       rx_m, rx_s, rx_p, wide;
  logic [8:0] sh;
  phase_t     ph;
  logic [3:0] sub, bit_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      rx_p <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
      rx_p <= rx_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      sub      <= '0;
      bit_i    <= '0;
      sh       <= '0;
      wide     <= 1'b0;
      done     <= 1'b0;
      data     <= '0;
      stop_bit <= 1'b1;
    end else begin
      done <= 1'b0;
      if (!en) begin
        ph <= PH_IDLE;
      end else begin
        case (ph)
          PH_IDLE: begin
            if (rx_p && !rx_s) begin
              ph   <= PH_START;
              sub  <= '0;
              wide <= chr9;
            end
          end
          PH_START: if (tick) begin
            if (sub == MID_SUB) begin
              if (rx_s) ph <= PH_IDLE;
              else begin
                ph    <= PH_DATA;
                sub   <= '0;
                bit_i <= '0;
              end
            end else sub <= sub + 1'b1;
          end
          PH_DATA: if (tick) begin
            if (sub == LAST_SUB) begin
              sub <= '0;
              sh  <= {rx_s, sh[8:1]};
              if (bit_i == (wide ? 4'd8 : 4'd7)) ph <= PH_STOP;
              else bit_i <= bit_i + 1'b1;
            end else sub <= sub + 1'b1;
          end
          PH_STOP: if (tick) begin
            if (sub == LAST_SUB) begin
              ph       <= PH_IDLE;
              done     <= 1'b1;
              stop_bit <= rx_s;
              data     <= wide ? sh : {1'b0, sh[8:1]};
            end else sub <= sub + 1'b1;
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (ph == PH_IDLE));

  assert_noise_rejected_R13: assert property (@(posedge clk) disable iff (rst)
    (en && ph == PH_START && tick && sub == MID_SUB && rx_s) |=> (ph == PH_IDLE));
endmodule

// File: rtl/uart9_port.sv
module uart9_port
  import uart9_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int DIV_RST = 25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       irq_rx,
  output logic       irq_tx,
  output logic       irq_empty
);
  logic             en_rxi, en_txi, en_emi, rx_on, tx_on, chr9, tx_b8;
  logic [DIV_W-1:0] div_q;
  logic             tick;
  logic [7:0]       rx_data;
  logic             rx_b8, rx_full, ferr, ovr_pend, ovr_vis, txc;
  logic             tx_full, tx_done, rx_done, rx_stop;
  logic [8:0]       rx_word;
  logic             wr_data, rd_data, wr_stat, wr_ctrl, wr_div;

  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_div  = bus_wr && (bus_addr == A_DIV);
  assign rd_data = bus_rd && (bus_addr == A_DATA);

  uart9_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .div(div_q), .tick(tick));

  uart9_tx u_tx (
    .clk(clk), .rst(rst), .tick(tick), .en(tx_on), .chr9(chr9),
    .wr(wr_data), .wdata({tx_b8, bus_wdata}),
    .txd(txd), .buf_full(tx_full), .done_pulse(tx_done));

  uart9_rx u_rx (
    .clk(clk), .rst(rst), .tick(tick), .en(rx_on), .chr9(chr9), .rxd(rxd),
    .done(rx_done), .data(rx_word), .stop_bit(rx_stop));

  always_ff @(posedge clk) begin
    if (rst) begin
      {en_rxi, en_txi, en_emi, rx_on, tx_on, chr9, tx_b8} <= '0;
      div_q <= DIV_W'(DIV_RST);
    end else begin
      if (wr_ctrl) begin
        {en_rxi, en_txi, en_emi, rx_on, tx_on, chr9} <= bus_wdata[7:2];
        tx_b8 <= bus_wdata[0];
      end
      if (wr_div) div_q <= {{(DIV_W-8){1'b0}}, bus_wdata};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      rx_b8    <= 1'b1;
      rx_full  <= 1'b0;
      ferr     <= 1'b0;
      ovr_pend <= 1'b0;
      ovr_vis  <= 1'b0;
    end else if (rx_done && rx_on && (!rx_full || rd_data)) begin
      rx_data  <= rx_word[7:0];
      if (chr9) rx_b8 <= rx_word[8];
      rx_full  <= 1'b1;
      ferr     <= !rx_stop;
      ovr_pend <= 1'b0;
      ovr_vis  <= 1'b0;
    end else begin
      if (rx_done && rx_on) ovr_pend <= 1'b1;
      if (rd_data) begin
        rx_full  <= 1'b0;
        ovr_pend <= 1'b0;
        if (ovr_pend) ovr_vis <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) txc <= 1'b0;
    else if (tx_done) txc <= 1'b1;
    else if (wr_stat && bus_wdata[1]) txc <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_rx    <= 1'b0;
      irq_tx    <= 1'b0;
      irq_empty <= 1'b0;
    end else begin
      irq_rx    <= rx_full & en_rxi;
      irq_tx    <= txc & en_txi;
      irq_empty <= !tx_full & en_emi;
      if (bus_rd) begin
        case (bus_addr)
          A_DATA:  bus_rdata <= rx_data;
          A_STAT:  bus_rdata <= {3'b000, ovr_vis, ferr, !tx_full, txc, rx_full};
          A_CTRL:  bus_rdata <= {en_rxi, en_txi, en_emi, rx_on, tx_on, chr9, rx_b8, 1'b0};
          default: bus_rdata <= div_q[7:0];
        endcase
      end
    end
  end

  assert_ovr_after_read_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_vis) |-> $past(rd_data));

  assert_rx_flag_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> $past(rx_on));

  assert_txc_line_idle_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(txc) |-> txd);

  assert_irq_low_no_flag_R12: assert property (@(posedge clk) disable iff (rst)
    !rx_full && !$past(rx_full) |-> !irq_rx);
endmodule

// File: tb/uart9_port_tb.sv
module uart9_port_tb;
  localparam logic [1:0] A_DATA = 2'd0, A_STAT = 2'd1, A_CTRL = 2'd2, A_DIV = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic rxd = 1'b1;
  logic txd, irq_rx, irq_tx, irq_empty;

  int n_checks = 0;
  int n_fail = 0;
  logic finished = 1'b0;

  typedef struct { int nb; logic [8:0] d; } frame_t;
  frame_t exp_q[$];

  always #2 clk = ~clk;

  uart9_port u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_empty(irq_empty));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_rx(input int nb, input logic [8:0] d, input logic stopv);
    @(negedge clk);
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      repeat (16) @(negedge clk);
    end
    rxd = stopv;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_tx(input int nb, input logic [8:0] d);
    frame_t f;
    f.nb = nb; f.d = d;
    exp_q.push_back(f);
  endtask

  // Scoreboard monitor: decode each frame on txd and compare with the queue.
  initial begin
    logic [8:0] got;
    frame_t f;
    forever begin
      @(negedge txd);
      repeat (8) @(negedge clk);
      chk("R2 start bit", 16'(txd), 16'h0);
      if (exp_q.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R9: actual unexpected frame expected no frame");
        f.nb = 8; f.d = '0;
      end else f = exp_q.pop_front();
      got = '0;
      for (int i = 0; i < f.nb; i++) begin
        repeat (16) @(negedge clk);
        got[i] = txd;
      end
      chk(f.nb == 9 ? "R3 nine-bit frame" : "R2 frame data", 16'(got), 16'(f.d));
      repeat (16) @(negedge clk);
      chk("R2 stop bit", 16'(txd), 16'h1);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    bus_read(A_CTRL, v); chk("R1 control reset", 16'(v), 16'h02);
    bus_read(A_STAT, v); chk("R1 status reset", 16'(v), 16'h04);
    chk("R1 txd idle", 16'(txd), 16'h1);
    chk("R1 irqs low", 16'({irq_rx, irq_tx, irq_empty}), 16'h0);
    bus_write(A_DIV, 8'h00);

    // R10 / R9: buffered while disabled, no frame starts
    bus_write(A_DATA, 8'h3C);
    bus_read(A_STAT, v); chk("R10 empty cleared by write", 16'(v & 8'h04), 16'h0);
    wait_clk(50);
    chk("R9 disabled holds line", 16'(txd), 16'h1);
    push_tx(8, 9'h03C);
    bus_write(A_CTRL, 8'h08);
    wait_clk(3);
    bus_read(A_STAT, v); chk("R10 empty set on load", 16'(v & 8'h06), 16'h04);
    wait_clk(200);
    bus_read(A_STAT, v); chk("R11 tx complete set", 16'(v & 8'h06), 16'h06);
    bus_write(A_STAT, 8'h02);
    bus_read(A_STAT, v); chk("R11 tx complete cleared", 16'(v & 8'h02), 16'h0);

    // R3 nine-bit transmit
    bus_write(A_CTRL, 8'h0D);
    push_tx(9, 9'h15A);
    bus_write(A_DATA, 8'h5A);
    bus_read(A_CTRL, v); chk("R3 tx ninth bit reads zero", 16'(v), 16'h0E);
    wait_clk(220);

    // R9 deferred disable
    bus_write(A_CTRL, 8'h08);
    push_tx(8, 9'h011);
    push_tx(8, 9'h022);
    bus_write(A_DATA, 8'h11);
    wait_clk(3);
    bus_write(A_DATA, 8'h22);
    bus_write(A_CTRL, 8'h00);
    wait_clk(400);
    bus_read(A_STAT, v); chk("R9 drained after disable", 16'(v & 8'h06), 16'h06);
    bus_write(A_DATA, 8'h33);
    wait_clk(200);
    bus_read(A_STAT, v); chk("R10 buffer held while disabled", 16'(v & 8'h04), 16'h0);
    push_tx(8, 9'h033);
    bus_write(A_CTRL, 8'h08);
    wait_clk(200);

    // R12 transmit-side interrupts
    bus_write(A_CTRL, 8'h68);
    wait_clk(2);
    chk("R12 irq_empty", 16'(irq_empty), 16'h1);
    chk("R12 irq_tx", 16'(irq_tx), 16'h1);
    bus_write(A_STAT, 8'h02);
    wait_clk(2);
    chk("R12 irq_tx cleared", 16'(irq_tx), 16'h0);
    bus_write(A_CTRL, 8'h00);
    wait_clk(2);
    chk("R12 irq_empty masked", 16'(irq_empty), 16'h0);

    // R4 receive
    bus_write(A_CTRL, 8'h10);
    send_rx(8, 9'h096, 1'b1);
    bus_read(A_STAT, v); chk("R4 receive complete", 16'(v & 8'h19), 16'h01);
    bus_read(A_DATA, v); chk("R4 received byte", 16'(v), 16'h96);
    bus_read(A_STAT, v); chk("R4 flag cleared by read", 16'(v & 8'h01), 16'h0);

    // R3 nine-bit receive
    bus_write(A_CTRL, 8'h14);
    send_rx(9, 9'h0A5, 1'b1);
    bus_read(A_CTRL, v); chk("R3 rx ninth bit zero", 16'(v & 8'h02), 16'h0);
    bus_read(A_DATA, v); chk("R3 rx low byte", 16'(v), 16'hA5);
    send_rx(9, 9'h1C3, 1'b1);
    bus_read(A_CTRL, v); chk("R3 rx ninth bit one", 16'(v & 8'h02), 16'h02);
    bus_read(A_DATA, v); chk("R3 rx low byte", 16'(v), 16'hC3);

    // R7 framing error
    bus_write(A_CTRL, 8'h10);
    send_rx(8, 9'h044, 1'b0);
    bus_read(A_STAT, v); chk("R7 framing error set", 16'(v & 8'h08), 16'h08);
    bus_read(A_DATA, v); chk("R7 data with bad stop", 16'(v), 16'h44);
    send_rx(8, 9'h045, 1'b1);
    bus_read(A_STAT, v); chk("R7 framing error cleared", 16'(v & 8'h08), 16'h0);
    bus_read(A_DATA, v);

    // R5 / R6 overrun
    send_rx(8, 9'h001, 1'b1);
    send_rx(8, 9'h002, 1'b1);
    bus_read(A_STAT, v); chk("R5 overrun hidden", 16'(v & 8'h11), 16'h01);
    bus_read(A_DATA, v); chk("R5 old byte kept", 16'(v), 16'h01);
    bus_read(A_STAT, v); chk("R5 overrun visible", 16'(v & 8'h11), 16'h10);
    send_rx(8, 9'h003, 1'b1);
    bus_read(A_STAT, v); chk("R6 overrun cleared", 16'(v & 8'h11), 16'h01);
    bus_read(A_DATA, v); chk("R6 new byte", 16'(v), 16'h03);

    // R8 receiver disable
    bus_write(A_CTRL, 8'h00);
    send_rx(8, 9'h055, 1'b1);
    bus_read(A_STAT, v); chk("R8 no flags while off", 16'(v & 8'h19), 16'h0);
    bus_write(A_CTRL, 8'h10);
    send_rx(8, 9'h066, 1'b1);
    bus_write(A_CTRL, 8'h00);
    bus_read(A_STAT, v); chk("R8 flag kept after off", 16'(v & 8'h01), 16'h01);
    bus_read(A_DATA, v); chk("R8 byte kept", 16'(v), 16'h66);

    // R13 noise rejection
    bus_write(A_CTRL, 8'h10);
    @(negedge clk); rxd = 1'b0;
    wait_clk(4);
    rxd = 1'b1;
    wait_clk(300);
    bus_read(A_STAT, v); chk("R13 glitch ignored", 16'(v & 8'h01), 16'h0);
    send_rx(8, 9'h077, 1'b1);
    bus_read(A_DATA, v); chk("R13 next frame received", 16'(v), 16'h77);

    // R12 receive interrupt
    bus_write(A_CTRL, 8'h90);
    send_rx(8, 9'h05E, 1'b1);
    wait_clk(2);
    chk("R12 irq_rx", 16'(irq_rx), 16'h1);
    bus_read(A_DATA, v);
    wait_clk(2);
    chk("R12 irq_rx cleared", 16'(irq_rx), 16'h0);

    chk("R9 all frames seen", 16'(exp_q.size()), 16'h0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule